// File: doc/BRIEF.md
# Carry-Save Interval Timer

This block measures a fixed interval that starts when a load strobe is applied, and reports when the interval has run out. It never forms a binary count. Its state is a redundant pair of registers, a sum word and a carry word. Each clock adds one through the lowest carry position. Carries move up by exactly one bit per clock, so the only logic between registers is a single row of half-adders, and the cycle time does not grow with the width.

The cost is that the interval is not a plain terminal count. For a width `W` and a loaded value `v`, the timer runs for `n = 2^W + W - v - 2` idle cycles. After that the done level rises and stays high. A one-cycle pulse marks the cycle in which the level rises. The block suits long, cheap timeouts in which the owner picks `v` from the wanted delay. Reset puts the block in the same state as a load of zero.

Top module: `cs_timer`

## Requirements
- R1: During synchronous active-low reset all state clears. In the first cycle after reset, `done_o` and `done_pulse_o` are low. From then on the timer behaves as if zero had been loaded in the last reset cycle.
- R2: In any cycle where `load_i` is high, `done_o` is low, whatever state the timer is in.
- R3: With `load_i` high only in cycle t, carrying value v, and with n = 2^W + W - v - 2, `done_o` in cycle t+k is high exactly when k > n. This holds for every v from 0 to 2^W-1.
- R4: Once `done_o` is high it stays high on every following cycle until `load_i` is raised again.
- R5: `done_pulse_o` is high in a cycle exactly when `done_o` is high in that cycle and was low in the cycle before. In the R3 scenario this happens only at k = n+1, for one cycle.
- R6: A load applied while a previous interval is still running, or after it has finished, restarts the timing from the new load cycle. Nothing of the earlier interval remains.
- R7: If `load_i` is held high for several consecutive cycles, the interval is measured from the last cycle in which it was high. The value used is the one present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe; starts a new interval |
| init_i | input | W | Start value sampled with the strobe |
| done_o | output | 1 | Sticky interval-elapsed level (combinational from state and strobe) |
| done_pulse_o | output | 1 | One-cycle marker of the rising edge of `done_o` |

## Verification
A behavioural model counts the cycles since the last load and predicts both outputs on every cycle. It is driven through a sweep of every legal start value, which separates a wrong half-adder row or an off-by-one carry injection from correct timing, because each value gives a distinct interval. Long idle stretches after expiry test stickiness. Reloads in mid-interval and after expiry test that the timer restarts cleanly. A multi-cycle strobe with a changing value tells apart sampling on the first cycle from sampling on the last. The reset-only start tests that reset acts as a load of zero.

// File: rtl/cs_timer_pkg.sv
// Package: shared types and helpers for the carry-save interval timer.
// Assumes: nothing beyond plain single-bit logic.
package cs_timer_pkg;

    // Result of one half-adder position: the sum bit stays, the carry moves up.
    typedef struct packed {
        logic sum;
        logic cry;
    } ha_bit_t;

    // One half-adder evaluation.
    function automatic ha_bit_t half_add(input logic a, input logic b);
        ha_bit_t r;
        r.sum = a ^ b;
        r.cry = a & b;
        return r;
    endfunction

endpackage

// File: rtl/cs_chain.sv
// Module: carry-save state of the timer.
// Holds a (W-1)-bit sum word and a W-bit carry word. Each idle cycle it
// inverts the lowest carry bit and passes one half-adder row across the
// words. A load places the start value across the sum word and carry bit 0.
// Assumes: W >= 2, and that load_i is synchronous to clk.
module cs_chain
    import cs_timer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] init_i,
    output logic         carry_top_o
);
    localparam int SW = W - 1;

    logic [SW-1:0] s_q, s_nx;
    logic [W-1:0]  c_q, c_nx;
    ha_bit_t       ha [SW];

    // One half-adder per sum position.
    for (genvar i = 0; i < SW; i++) begin : g_row
        assign ha[i] = half_add(s_q[i], c_q[i]);
    end

    // Gathers the half-adder row into the next words; bit 0 takes the increment.
    always_comb begin
        c_nx[0] = ~c_q[0];
        for (int i = 0; i < SW; i++) begin
            s_nx[i]   = ha[i].sum;
            c_nx[i+1] = ha[i].cry;
        end
    end

    // State update: reset, load or advance by one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            c_q <= '0;
        end else if (load_i) begin
            s_q <= init_i[W-1:1];
            c_q <= {{(W-1){1'b0}}, init_i[0]};
        end else begin
            s_q <= s_nx;
            c_q <= c_nx;
        end
    end

    assign carry_top_o = c_q[W-1];

    // R6 / R7: a load leaves no carries above bit 0.
    a_r6_load_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (c_q[W-1:1] == '0));

    // R7: the low bit of the carry word follows the loaded value.
    a_r7_load_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (c_q[0] == $past(init_i[0])));

    // R3: every idle cycle injects one count through the low carry bit.
    a_r3_low_bit_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (c_q[0] != $past(c_q[0])));

endmodule

// File: rtl/cs_done_latch.sv
// Module: sticky expiry flag.
// Sets once a carry leaves the top of the carry word. Clears on load.
// The output is the value the flag will take next, so it is low in any
// cycle where a load is being applied.
// Assumes: carry_top_i comes straight from a register.
module cs_done_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic carry_top_i,
    output logic done_o
);
    logic d_q;
    logic d_nx;

    // Next flag: clear on load, otherwise hold or pick up the top carry.
    always_comb begin
        d_nx = load_i ? 1'b0 : (d_q | carry_top_i);
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= 1'b0;
        else        d_q <= d_nx;
    end

    assign done_o = d_nx;

    // R4: the flag holds until a load.
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q && !load_i) |=> d_q);

    // R2: a load empties the flag.
    a_r2_load_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !d_q);

endmodule

// File: rtl/cs_rise_pulse.sv
// Module: rising-edge marker for the expiry level.
// Keeps the level of the previous cycle and flags a low-to-high change.
// Assumes: level_i is settled before each rising clock edge.
module cs_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);
    logic prev_q;

    // Previous-cycle copy of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Edge detect.
    assign pulse_o = level_i & ~prev_q;

    // R5: the marker never lasts two cycles.
    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/cs_timer.sv
// Module: carry-save interval timer (top).
// A load of v starts an interval of 2^W + W - v - 2 idle cycles. After it,
// done_o rises and stays high, and done_pulse_o marks the rising cycle.
// Assumes: W >= 2; synchronous active-low reset, equivalent to loading zero.
module cs_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] init_i,
    output logic         done_o,
    output logic         done_pulse_o
);
    logic carry_top;

    cs_chain #(.W(W)) chain_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .init_i      (init_i),
        .carry_top_o (carry_top)
    );

    cs_done_latch latch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .carry_top_i (carry_top),
        .done_o      (done_o)
    );

    cs_rise_pulse edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (done_o),
        .pulse_o (done_pulse_o)
    );

    // R5: a marker only follows a cycle in which the level was low.
    a_r5_pulse_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse_o |-> !$past(done_o));

    // R4: the output level holds until a load.
    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> (done_o || load_i));

endmodule

// File: tb/cs_timer_tb_top.sv
// Bench: a behavioural cycle-count model, compared with the timer on every cycle.
module cs_timer_tb_top;
    localparam int W    = 4;
    localparam int HALF = 10;   // 20 ns period, 50 MHz

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] init_i = '0;
    logic         done_o, done_pulse_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string phase = "R1 reset start";

    // Model state: cycles since the last load, interval limit, previous expected level.
    int since = 0;
    int lim   = 0;
    bit prev_exp = 0;
    bit exp_done, exp_pulse;

    cs_timer #(.W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .init_i       (init_i),
        .done_o       (done_o),
        .done_pulse_o (done_pulse_o)
    );

    always #HALF clk = ~clk;

    function automatic int interval(input int v);
        return (1 << W) + W - v - 2;
    endfunction

    always_comb begin
        exp_done  = rst_n && !load_i && (since > lim);
        exp_pulse = exp_done && !prev_exp;
    end

    // Model update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            since    <= 1;
            lim      <= interval(0);
            prev_exp <= 1'b0;
        end else if (load_i) begin
            since    <= 1;
            lim      <= interval(int'(init_i));
            prev_exp <= 1'b0;
        end else begin
            since    <= since + 1;
            prev_exp <= exp_done;
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (done_o !== exp_done) begin
                fails++;
                $display("FAIL %s done (%s) since=%0d lim=%0d: got %b expected %b",
                         load_i ? "R2" : (since > lim + 1 ? "R4" : "R3"), phase,
                         since, lim, done_o, exp_done);
            end
            checks++;
            if (done_pulse_o !== exp_pulse) begin
                fails++;
                $display("FAIL R5 pulse (%s) since=%0d lim=%0d: got %b expected %b",
                         phase, since, lim, done_pulse_o, exp_pulse);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_load(input int v);
        @(posedge clk); #2;
        load_i = 1'b1;
        init_i = W'(v);
        @(posedge clk); #2;
        load_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1: first cycle after reset is quiet.
        @(negedge clk); #1;
        checks++;
        if (done_o !== 1'b0 || done_pulse_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset: got %b%b expected 00", done_o, done_pulse_o);
        end
        // R1: timing from reset equals a load of zero.
        cyc(interval(0) + 6);

        // R3 / R5 / R4: every legal start value, with idle time after expiry.
        phase = "R3 sweep";
        for (int v = 0; v < (1 << W); v++) begin
            do_load(v);
            cyc(interval(v) + 5);
        end

        // R6: reload mid-interval, then after expiry.
        phase = "R6 reload";
        do_load(2);
        cyc(5);
        do_load(9);
        cyc(interval(9) + 4);
        do_load(0);
        cyc(interval(0) + 3);

        // R7: strobe held for three cycles with changing value.
        phase = "R7 long strobe";
        @(posedge clk); #2;
        load_i = 1'b1; init_i = W'(1);
        cyc(1); init_i = W'(7);
        cyc(1); init_i = W'(12);
        cyc(1); load_i = 1'b0;
        cyc(interval(12) + 4);

        // R2: strobe while the level is high.
        phase = "R2 load over done";
        do_load(14);
        cyc(interval(14) + 3);

        // R1: reset in mid-interval.
        phase = "R1 mid reset";
        do_load(3);
        cyc(4);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(interval(0) + 4);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(2 * HALF * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule